// File: doc/BRIEF.md
# Staggered Whole-Word Lane Distributor

This block sits between a parallel host bus that presents one 32-bit word per clock (with one control flag per byte) and four byte-wide transmit lanes. Instead of cutting each word into a column of four simultaneous bytes, it gives every word whole to a single lane. Successive words go to successive lanes in a fixed rotation, and each lane spends four clocks sending its word one byte per clock.

Each lane starts one clock after its neighbour, so a lane picks up its next word on the same edge that ends the previous one. No lane ever waits for later words before it starts. The rotation never stops. A clock with no valid host word is filled with an idle word made of four control bytes, so the lane cadence does not change. After reset, a lane that has not yet been given a word sends the idle control character. Line coding and serialization happen downstream.

Top module: `wstripe_tx`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, every lane outputs the idle character: control flag 1 and byte 0x07. The rotation restarts at lane 0.
- R2: Counting the clock edges after reset release as word slots n = 0, 1, 2, ..., the host word sampled in slot n is given to lane n mod 4.
- R3: Byte 0 of a word appears on its lane in the clock period that directly follows the edge that sampled the word.
- R4: A lane sends the bytes of its word in the order 0, 1, 2, 3, one per clock. Byte j occupies host bits [8j+7:8j]. The lane's next word follows with no gap.
- R5: Byte j of a word is held j clocks after the first byte leaves. The last byte leaves three clocks after the first.
- R6: Each byte is sent together with its own control flag. Host flag bit j goes out with byte j.
- R7: A lane that has not been loaded since reset outputs the idle character (flag 1, byte 0x07).
- R8: A slot in which `host_vld` is low is filled with an idle word: four bytes of 0x07, each with its flag set. The rotation still advances by one lane.
- R9: Lane k begins its words k clocks after lane 0 begins its words, so the four lanes run on windows offset by one clock each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host and lane clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_vld | input | 1 | Host word valid for this slot |
| host_data | input | 32 | Host word; byte j in bits [8j+7:8j] |
| host_ctl | input | 4 | Control flag per host byte |
| lane_data | output | 32 | Lane k output byte in bits [8k+7:8k] |
| lane_ctl | output | 4 | Lane k control flag in bit k |

## Verification
Two things can happen on the same edge: a lane reloads, and the last byte of its previous word ends. The same edge may also carry an invalid slot, which forces an idle fill for the word being loaded. Back-to-back valid words provoke the reload case, and gaps in `host_vld` placed at different offsets provoke the fill case. A reset in the middle of a stream checks that the lanes return to idle and the rotation restarts at lane 0. A scoreboard predicts every lane byte and flag for every clock. A reload that drops or repeats a byte, or a fill that lands on the wrong lane, shows up as a byte mismatch in the cycle where it happens.

// File: rtl/wstripe_pkg.sv
package wstripe_pkg;

   // Lane activity: waiting for the first word, or streaming words
   typedef enum logic {
      LN_WAIT = 1'b0,
      LN_BUSY = 1'b1
   } lane_state_e;

   // Default idle control character sent while a lane has no word
   localparam logic [7:0] IDLE_CHAR_DEF = 8'h07;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wstripe_sched.sv
// Slot rotation: one word slot per clock, handed to lanes in turn.
module wstripe_sched #(
   parameter int NUM_LANES = 4,
   localparam int PTR_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [NUM_LANES-1:0] load
);

   logic [PTR_W-1:0] slot_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_ptr <= '0;
      end else if (slot_ptr == PTR_W'(NUM_LANES - 1)) begin
         slot_ptr <= '0;
      end else begin
         slot_ptr <= slot_ptr + 1'b1;
      end
   end

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_dec
      assign load[k] = (slot_ptr == PTR_W'(k));
   end

   // R2: the rotation moves to the following lane on every clock
   a_r2_rotation_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load[NUM_LANES-1]) |-> load[0]);

   a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(load) == 1);

endmodule

// File: rtl/wstripe_fill.sv
// Slot content: the host word when valid, otherwise an all-control idle word.
module wstripe_fill #(
   parameter int              BYTE_W    = 8,
   parameter int              NUM_BYTES = 4,
   parameter logic [BYTE_W-1:0] IDLE_CHAR = 'h07,
   localparam int             WORD_W    = BYTE_W * NUM_BYTES
) (
   input  logic                 vld,
   input  logic [WORD_W-1:0]    in_data,
   input  logic [NUM_BYTES-1:0] in_ctl,
   output logic [WORD_W-1:0]    slot_data,
   output logic [NUM_BYTES-1:0] slot_ctl
);

   logic [WORD_W-1:0] idle_word;

   for (genvar j = 0; j < NUM_BYTES; j++) begin : g_idle
      assign idle_word[j*BYTE_W +: BYTE_W] = IDLE_CHAR;
   end

   always_comb begin
      if (vld) begin
         slot_data = in_data;
         slot_ctl  = in_ctl;
      end else begin
         slot_data = idle_word;
         slot_ctl  = '1;
      end
   end

endmodule

// File: rtl/wstripe_lane.sv
// One lane: holds a whole word and releases it one byte per clock.
module wstripe_lane
   import wstripe_pkg::*;
#(
   parameter int                BYTE_W    = 8,
   parameter int                NUM_BYTES = 4,
   parameter logic [BYTE_W-1:0] IDLE_CHAR = 'h07,
   localparam int               WORD_W    = BYTE_W * NUM_BYTES,
   localparam int               IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [WORD_W-1:0]    word_data,
   input  logic [NUM_BYTES-1:0] word_ctl,
   output logic [BYTE_W-1:0]    out_byte,
   output logic                 out_ctl
);

   lane_state_e              state;
   logic [WORD_W-1:0]        hold_data;
   logic [NUM_BYTES-1:0]     hold_ctl;
   logic [IDX_W-1:0]         byte_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= LN_WAIT;
         hold_data <= '0;
         hold_ctl  <= '0;
         byte_idx  <= '0;
      end else if (load) begin
         state     <= LN_BUSY;
         hold_data <= word_data;
         hold_ctl  <= word_ctl;
         byte_idx  <= '0;
      end else if (state == LN_BUSY) begin
         byte_idx  <= byte_idx + 1'b1;
      end
   end

   always_comb begin
      if (state == LN_WAIT) begin
         out_byte = IDLE_CHAR;
         out_ctl  = 1'b1;
      end else begin
         out_byte = hold_data[byte_idx*BYTE_W +: BYTE_W];
         out_ctl  = hold_ctl[byte_idx];
      end
   end

   // R4: a busy lane is reloaded only as its last byte ends
   a_r4_reload_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (load && state == LN_BUSY) |-> byte_idx == IDX_W'(NUM_BYTES - 1));

   // R4: between loads the byte index only moves forward by one
   a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(state) == LN_BUSY && state == LN_BUSY)
      |-> byte_idx == $past(byte_idx) + 1'b1);

endmodule

// File: rtl/wstripe_tx.sv
// Top: whole-word striping over staggered byte lanes.
module wstripe_tx
   import wstripe_pkg::*;
#(
   parameter int                NUM_LANES = 4,
   parameter int                BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] IDLE_CHAR = IDLE_CHAR_DEF,
   localparam int               WORD_W    = NUM_LANES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_vld,
   input  logic [WORD_W-1:0]    host_data,
   input  logic [NUM_LANES-1:0] host_ctl,
   output logic [WORD_W-1:0]    lane_data,
   output logic [NUM_LANES-1:0] lane_ctl
);

   // The byte count per word equals the lane count so reloads meet word ends
   if (!is_pow2(NUM_LANES)) begin : g_chk_lanes
      $error("wstripe_tx: NUM_LANES must be a power of two");
   end
   if (BYTE_W < 1) begin : g_chk_byte
      $error("wstripe_tx: BYTE_W must be positive");
   end

   logic [NUM_LANES-1:0] load;
   logic [WORD_W-1:0]    slot_data;
   logic [NUM_LANES-1:0] slot_ctl;

   wstripe_sched #(.NUM_LANES(NUM_LANES)) u_sched (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load)
   );

   wstripe_fill #(
      .BYTE_W    (BYTE_W),
      .NUM_BYTES (NUM_LANES),
      .IDLE_CHAR (IDLE_CHAR)
   ) u_fill (
      .vld       (host_vld),
      .in_data   (host_data),
      .in_ctl    (host_ctl),
      .slot_data (slot_data),
      .slot_ctl  (slot_ctl)
   );

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      wstripe_lane #(
         .BYTE_W    (BYTE_W),
         .NUM_BYTES (NUM_LANES),
         .IDLE_CHAR (IDLE_CHAR)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load[k]),
         .word_data (slot_data),
         .word_ctl  (slot_ctl),
         .out_byte  (lane_data[k*BYTE_W +: BYTE_W]),
         .out_ctl   (lane_ctl[k])
      );
   end

   // Edges seen since reset release, saturating; qualifies $past windows
   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != '1)  age <= age + 1'b1;
   end

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_chk
      // R3 R6: first byte and its flag leave in the cycle after the word arrives
      a_r3_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 3'd1 && $past(load[k]) && $past(host_vld))
         |-> (lane_data[k*BYTE_W +: BYTE_W] == $past(host_data[0 +: BYTE_W])
              && lane_ctl[k] == $past(host_ctl[0])));

      // R5: the last byte leaves NUM_LANES-1 clocks after the first
      a_r5_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 3'd4 && $past(load[k], 4) && $past(host_vld, 4))
         |-> (lane_data[k*BYTE_W +: BYTE_W]
                 == $past(host_data[(NUM_LANES-1)*BYTE_W +: BYTE_W], 4)
              && lane_ctl[k] == $past(host_ctl[NUM_LANES-1], 4)));

      // R8: an empty slot sends the idle character as a control byte
      a_r8_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 3'd1 && $past(load[k]) && !$past(host_vld))
         |-> (lane_ctl[k] && lane_data[k*BYTE_W +: BYTE_W] == IDLE_CHAR));
   end

endmodule

// File: tb/wstripe_tx_test.sv
module wstripe_tx_test;

   localparam int NL = 4;
   localparam int BW = 8;
   localparam logic [7:0] IDLE = 8'h07;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_vld = 1'b0;
   logic [31:0]   host_data = '0;
   logic [3:0]    host_ctl = '0;
   logic [31:0]   lane_data;
   logic [3:0]    lane_ctl;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int nword  = 0;
   bit done   = 1'b0;

   // entry: {kind[1:0], ctl, byte}; kind 0 = host data, 1 = idle fill
   logic [10:0] expq [NL][$];

   wstripe_tx uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_vld  (host_vld),
      .host_data (host_data),
      .host_ctl  (host_ctl),
      .lane_data (lane_data),
      .lane_ctl  (lane_ctl)
   );

   always #10 clk = ~clk;

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Monitor: pop one expected byte per lane every cycle, away from the edge
   always @(posedge clk) begin
      #5;
      cycles++;
      if (!done && cycles > 5000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
         finish_run();
      end
      for (int k = 0; k < NL; k++) begin
         logic [8:0] expv;
         logic [8:0] gotv;
         string      tag;
         gotv = {lane_ctl[k], lane_data[k*BW +: BW]};
         if (!rst_n) begin
            expv = {1'b1, IDLE};
            tag  = "R1";
         end else if (expq[k].size() == 0) begin
            expv = {1'b1, IDLE};
            tag  = "R7";
         end else begin
            logic [10:0] e;
            e    = expq[k].pop_front();
            expv = e[8:0];
            tag  = (e[10:9] == 2'd1) ? "R8" : "R4/R6";
         end
         checks++;
         if (gotv !== expv) begin
            fails++;
            $display("FAIL %s lane %0d: got %h expected %h", tag, k, gotv, expv);
         end
      end
   end

   // R2 R3 R5 R9: word n queues four bytes, in order, on lane n mod 4
   task automatic push_word(input bit vld, input logic [31:0] d, input logic [3:0] c);
      for (int j = 0; j < NL; j++) begin
         if (vld) expq[nword % NL].push_back({2'd0, c[j], d[j*BW +: BW]});
         else     expq[nword % NL].push_back({2'd1, 1'b1, IDLE});
      end
      nword++;
   endtask

   task automatic send(input bit vld, input logic [31:0] d, input logic [3:0] c);
      @(negedge clk);
      host_vld  = vld;
      host_data = d;
      host_ctl  = c;
      push_word(vld, d, c);
   endtask

   // R1: reset clears the lanes and restarts the rotation at lane 0
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int k = 0; k < NL; k++) expq[k].delete();
      nword = 0;
      repeat (3) @(negedge clk);
      rst_n     = 1'b1;
      host_vld  = 1'b0;
      host_data = 32'hDEAD_BEEF;
      host_ctl  = 4'h0;
      push_word(1'b0, '0, '0);
   endtask

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'h1357_9BDF;
      do_reset();
      // R7: lanes 1..3 idle until their first slot arrives (slot 0 was empty)
      for (int i = 0; i < 8; i++) send(1'b1, {4{8'(8'h10 + i)}} ^ 32'h0302_0100, 4'h0);
      for (int i = 0; i < 4; i++) send(1'b0, 32'hFFFF_FFFF, 4'h0);   // R8
      for (int i = 0; i < 16; i++) begin                              // R6
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         send(1'b1, lfsr, 4'(i));
      end
      for (int i = 0; i < 12; i++) send(i[0], 32'hA5A5_0000 + i, 4'(i * 5)); // R8 gaps
      for (int i = 0; i < 3; i++) send(1'b0, '0, '0);
      send(1'b1, 32'h4433_2211, 4'b1001);
      do_reset();                                                    // R1 mid-stream
      for (int i = 0; i < 6; i++) send(1'b1, 32'hC0DE_0000 + i, 4'b0101);
      for (int i = 0; i < 8; i++) send(1'b0, '0, '0);
      @(posedge clk);
      #6;
      finish_run();
   end

endmodule